// File: doc/BRIEF.md
# Atomic-update 32-pin GPIO port

This block is a 32-pin general-purpose I/O port that sits behind a simple 32-bit register bus. Software never needs a read-modify-write to change one pin. Direction has two registers. A write of ones to the first register turns those pins into outputs. A write of ones to the second register turns those pins back into inputs.

Output levels are written through two registers, one for each 16-pin half of the port. The upper 16 bits of each write select the pins that take the lower 16 bits. A level may be stored while a pin is still an input. That level appears on the pad at the moment the pin becomes an output. Pad levels reach the bus through a two-flop synchronizer.

The bus has single-cycle write and read strobes. Read data is registered.

Top module: `gpio_mask_port`

## Requirements
- R1: A write to offset 0x00 makes an output of every pin whose data bit is 1. Pins whose data bit is 0 keep their direction.
- R2: A write to offset 0x04 makes an input of every pin whose data bit is 1. Pins whose data bit is 0 keep their direction.
- R3: A write to offset 0x08 updates the stored levels of pins 0..15. For each pin i, bit 16+i enables the update and bit i is the new level. Pins whose enable bit is 0 keep their stored level.
- R4: A write to offset 0x0C does the same for pins 16..31, with pin 16+i taking bit i under enable bit 16+i. Pins 0..15 are untouched.
- R5: A level stored while a pin is an input does not reach `pad_out`. It appears on `pad_out` in the cycle after that pin is made an output.
- R6: `pad_oe` equals the direction vector, where 1 means output. A `pad_out` bit is 0 whenever its `pad_oe` bit is 0. Direction changes only on writes to offsets 0x00 and 0x04.
- R7: A read of offset 0x10 returns the pad levels after a two-flop synchronizer. A read sampled at the first or second clock edge after a pad change returns the old level. A read sampled at the third edge returns the new level.
- R8: Reads of 0x00 and 0x04 both return the direction vector. Reads of 0x08 and 0x0C return the stored levels of their half in bits 15:0 and zeros in bits 31:16. Any other offset reads as zero.
- R9: After reset all pins are inputs, all stored levels are 0, and `pad_oe`, `pad_out` and `rdata` are 0.
- R10: `rdata` is loaded at the clock edge that samples `rd_en`. It holds its value in cycles without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_oe | output | 32 | Per-pin output enable |
| pad_out | output | 32 | Per-pin output level |

## Verification
Writes take effect at the edge that samples `wr_en`, so the bench checks `pad_oe` and `pad_out` at the falling edge that follows. A read returns its data at the edge that samples `rd_en`, and the bench reads `rdata` half a cycle later. For the synchronizer, the bench changes the pads and holds a read of offset 0x10 for three edges. It expects the old level after the first two edges and the new level after the third.

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [31:0]       pad_in,
  output logic [31:0]       pad_oe,
  output logic [31:0]       pad_out
);
  localparam int HALF = 16;
  localparam logic [ADDR_W-1:0] A_DIR_SET = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_DIR_CLR = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_OUT_LO  = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_OUT_HI  = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_PIN_IN  = ADDR_W'(5'h10);

  logic [31:0] dir_q, lvl_q, sync1_q, sync2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (wr_en && addr == A_DIR_SET) begin
      dir_q <= dir_q | wdata;
    end else if (wr_en && addr == A_DIR_CLR) begin
      dir_q <= dir_q & ~wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < HALF; i++) begin
        if (addr == A_OUT_LO && wdata[HALF+i]) lvl_q[i]      <= wdata[i];
        if (addr == A_OUT_HI && wdata[HALF+i]) lvl_q[HALF+i] <= wdata[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        A_DIR_SET, A_DIR_CLR: rdata <= dir_q;
        A_OUT_LO:             rdata <= {16'b0, lvl_q[HALF-1:0]};
        A_OUT_HI:             rdata <= {16'b0, lvl_q[31:HALF]};
        A_PIN_IN:             rdata <= sync2_q;
        default:              rdata <= '0;
      endcase
    end
  end

  assign pad_oe  = dir_q;
  assign pad_out = lvl_q & dir_q;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [31:0]       pad_in,
  input logic [31:0]       pad_oe,
  input logic [31:0]       pad_out
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_dir_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(5'h00)) |=> pad_oe == ($past(pad_oe) | $past(wdata)));

  assert_dir_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(5'h04)) |=> pad_oe == ($past(pad_oe) & ~$past(wdata)));

  assert_lo_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(5'h08)) |=>
      (((pad_out[15:0] ^ $past(wdata[15:0])) & $past(wdata[31:16]) & pad_oe[15:0]) == 16'h0) &&
      (((pad_out[15:0] ^ $past(pad_out[15:0])) & ~$past(wdata[31:16])) == 16'h0));

  assert_hi_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(5'h0C)) |=>
      (((pad_out[31:16] ^ $past(wdata[15:0])) & $past(wdata[31:16]) & pad_oe[31:16]) == 16'h0) &&
      (pad_out[15:0] == $past(pad_out[15:0])));

  assert_dir_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == ADDR_W'(5'h00) || addr == ADDR_W'(5'h04))) |=> $stable(pad_oe));

  assert_undriven_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == 32'h0);

  assert_in_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(5'h10) && age == 2'd3) |=> rdata == $past(pad_in, 3));

  assert_reset_R9: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == 32'h0 && pad_out == 32'h0));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_gpio_mask_port.sv
`timescale 1ns/1ps
module sim_gpio_mask_port;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, pad_in = '0;
  logic [31:0] rdata, pad_oe, pad_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_mask_port #(.ADDR_W(5)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic t_reset;
    chk(pad_oe == 0, "R9 oe", pad_oe, 0);
    chk(pad_out == 0, "R9 out", pad_out, 0);
    chk(rdata == 0, "R9 rdata", rdata, 0);
  endtask

  task automatic t_direction;
    logic [31:0] d;
    wr(5'h00, 32'h0000_00F0);
    chk(pad_oe == 32'h0000_00F0, "R1 set", pad_oe, 32'h0000_00F0);
    wr(5'h00, 32'h8000_0001);
    chk(pad_oe == 32'h8000_00F1, "R1 set keeps others", pad_oe, 32'h8000_00F1);
    wr(5'h04, 32'h0000_0030);
    chk(pad_oe == 32'h8000_00C1, "R2 clear", pad_oe, 32'h8000_00C1);
    rd(5'h00, d);
    chk(d == 32'h8000_00C1, "R8 dir read 0x00", d, 32'h8000_00C1);
    rd(5'h04, d);
    chk(d == 32'h8000_00C1, "R8 dir read 0x04", d, 32'h8000_00C1);
    wr(5'h08, 32'hFFFF_FFFF);
    chk(pad_oe == 32'h8000_00C1, "R6 dir unchanged by level write", pad_oe, 32'h8000_00C1);
    wr(5'h00, 32'hFFFF_FFFF);
    wr(5'h08, 32'hFFFF_0000);
    wr(5'h0C, 32'hFFFF_0000);
  endtask

  task automatic t_levels;
    logic [31:0] d;
    wr(5'h08, 32'h00FF_A5A5);
    chk(pad_out == 32'h0000_00A5, "R3 masked low", pad_out, 32'h0000_00A5);
    wr(5'h08, 32'h0001_0000);
    chk(pad_out == 32'h0000_00A4, "R3 single pin", pad_out, 32'h0000_00A4);
    wr(5'h0C, 32'hF000_FFFF);
    chk(pad_out == 32'hF000_00A4, "R4 masked high", pad_out, 32'hF000_00A4);
    rd(5'h08, d);
    chk(d == 32'h0000_00A4, "R8 low readback", d, 32'h0000_00A4);
    rd(5'h0C, d);
    chk(d == 32'h0000_F000, "R8 high readback", d, 32'h0000_F000);
    rd(5'h14, d);
    chk(d == 32'h0, "R8 unmapped", d, 32'h0);
  endtask

  task automatic t_preload;
    wr(5'h04, 32'h0000_0600);
    wr(5'h08, 32'h0600_0600);
    chk(pad_out[10:9] == 2'b00, "R5 undriven while input", pad_out, pad_out & ~32'h600);
    chk(pad_oe[10:9] == 2'b00, "R6 oe low while input", pad_oe, pad_oe & ~32'h600);
    wr(5'h00, 32'h0000_0200);
    chk(pad_out[10:9] == 2'b01, "R5 preloaded appears", pad_out, (pad_out & ~32'h600) | 32'h200);
  endtask

  task automatic t_input;
    logic [31:0] d;
    @(negedge clk); pad_in = 32'h1234_5678;
    repeat (4) @(negedge clk);
    rd(5'h10, d);
    chk(d == 32'h1234_5678, "R7 settled", d, 32'h1234_5678);
    rd(5'h00, d);
    @(negedge clk); pad_in = 32'hCAFE_F00D; rd_en = 1; addr = 5'h10;
    @(negedge clk);
    chk(rdata == 32'h1234_5678, "R7 edge1 old", rdata, 32'h1234_5678);
    @(negedge clk);
    chk(rdata == 32'h1234_5678, "R7 edge2 old", rdata, 32'h1234_5678);
    @(negedge clk); rd_en = 0;
    chk(rdata == 32'hCAFE_F00D, "R7 edge3 new", rdata, 32'hCAFE_F00D);
    pad_in = 32'h0;
    repeat (3) @(negedge clk);
    chk(rdata == 32'hCAFE_F00D, "R10 holds without read", rdata, 32'hCAFE_F00D);
  endtask

  initial begin
    #12 t_reset();
    @(negedge clk); rst_n = 1;
    t_direction();
    t_levels();
    t_preload();
    t_input();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule